// File: doc/BRIEF.md
# Low-Zero-Density Serial EEPROM Controller

This block is a bus master for a two-wire serial EEPROM that uses 16-bit memory addressing. It runs one transfer at a time: a single-byte write or a single-byte random read. Every byte it sends is chosen so that as few bits as possible hold the line low. Each low level on an open-drain line draws current through its pull-up, so fewer zeros means less power.

Three rules shape the bytes on the wire. The three strap bits of the device address are fixed at ones. The unused upper bits of the 16-bit memory address are always sent as ones. Data is inverted on the wire in both directions, so the host writes and reads plain values. The host starts a transfer with a request strobe. It sees busy for the whole transfer and one done pulse at the end, with the read data and the error flag valid at that pulse. SCL and SDA are open-drain: an output-enable of 1 pulls the line low, and SDA is sampled through a separate input.

Top module: `lz_eeprom_ctrl`

## Requirements
- R1: After reset, busy, done and err are 0 and both output enables are 0 (both lines released).
- R2: The first byte after every START is 0xAE: the device code 1010, strap bits 111, and R/W = 0.
- R3: The memory-address high byte is {3'b111, addr[12:8]} and the low byte is addr[7:0]. Logical 0x1BCC gives 0xFB, 0xCC; logical 0x0000 gives 0xE0, 0x00.
- R4: A write sends the bitwise inverse of wdata, so 0x00 goes out as 0xFF and 0xA5 as 0x5A.
- R5: A write sends, in this order, the control byte, the address high byte, the address low byte and the data byte, and no other byte.
- R6: A read sends the control byte and both address bytes, then a repeated START and 0xAF. It receives one byte, answers it with NACK (SDA high on the ninth clock), and returns the bitwise inverse of the received byte on rdata.
- R7: Inside a byte, SDA changes only while SCL is low. Only START and STOP change SDA while SCL is high.
- R8: If the slave answers any sent byte with NACK (SDA high on the ninth clock), the controller sends no further byte, issues STOP and reports err = 1 with done. A later transfer that succeeds reports err = 0.
- R9: Busy is 1 from the cycle after a request is accepted until the transfer ends. Done is a single-cycle pulse during which busy is 0.
- R10: Whenever busy is 0, both output enables are 0.
- R11: During a transfer, successive rising edges of SCL are 4 * QTR_CYC system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a transfer (accepted while idle) |
| rd_nwr | input | 1 | 1 = random read, 0 = byte write |
| addr | input | AW | Logical byte address |
| wdata | input | 8 | Byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 8 | Byte read, valid at done |
| err | output | 1 | Slave refused a byte, valid at done |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled level of the SDA line |

## Verification
Two decisions fall on the same quarter-phase tick: the end of a byte's acknowledge slot picks the next byte to send, and a refused acknowledge redirects the controller to STOP. A bench slave model refuses a chosen byte, either the address-high byte of a write or the control byte of a read. The bench then checks three things: that exactly the bytes up to and including the refused one reached the wire, that a STOP followed, and that done came with err set. A clean transfer right afterwards must clear err, which shows the refusal state does not leak into the next request.

// File: rtl/lz_pkg.sv
package lz_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_BIT, ST_RSTART, ST_STOP} lz_state_t;
  typedef enum logic [2:0] {B_CW, B_AH, B_AL, B_WD, B_CR, B_RD} lz_slot_t;
  localparam logic [3:0] DEV_FAMILY = 4'b1010;
endpackage

// File: rtl/lz_phase_gen.sv
module lz_phase_gen #(
  parameter int QTR_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/lz_tx_encode.sv
module lz_tx_encode
  import lz_pkg::*;
#(
  parameter int AW = 13,
  parameter logic [2:0] STRAP = 3'b111
) (
  input  lz_slot_t        sel,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      wire_byte
);
  localparam int PAD = 16 - AW;

  logic [15:0] maddr;

  // unused upper address bits are sent as ones
  generate
    if (PAD > 0) begin : g_pad
      assign maddr = {{PAD{1'b1}}, addr};
    end else begin : g_full
      assign maddr = addr[15:0];
    end
  endgenerate

  always_comb begin
    case (sel)
      B_CW:    wire_byte = {DEV_FAMILY, STRAP, 1'b0};
      B_CR:    wire_byte = {DEV_FAMILY, STRAP, 1'b1};
      B_AH:    wire_byte = maddr[15:8];
      B_AL:    wire_byte = maddr[7:0];
      B_WD:    wire_byte = ~wdata;
      default: wire_byte = 8'hFF;
    endcase
  end
endmodule

// File: rtl/lz_eeprom_ctrl.sv
module lz_eeprom_ctrl
  import lz_pkg::*;
#(
  parameter int QTR_CYC = 4,
  parameter int AW = 13,
  parameter logic [2:0] STRAP = 3'b111
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          rd_nwr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rdata,
  output logic          err,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_i
);
  localparam logic [3:0] ACK_BIT = 4'd8;

  lz_state_t     state;
  lz_slot_t      slot, slot_nx, enc_sel;
  logic [1:0]    step;
  logic [3:0]    bitn;
  logic [7:0]    sh, rx, enc_byte;
  logic          ack_bad, nack_q, rw_q, tick;
  logic [AW-1:0] addr_q;
  logic [7:0]    wdata_q;
  logic          bit_phase;

  assign bit_phase = (state == ST_BIT);

  lz_phase_gen #(.QTR_CYC(QTR_CYC)) u_phase (
    .clk(clk), .rst(rst), .run(busy), .tick(tick)
  );

  always_comb begin
    case (slot)
      B_CW:    slot_nx = B_AH;
      B_AH:    slot_nx = B_AL;
      B_AL:    slot_nx = rw_q ? B_CR : B_WD;
      B_CR:    slot_nx = B_RD;
      default: slot_nx = slot;
    endcase
  end

  assign enc_sel = (state == ST_BIT) ? slot_nx : slot;

  lz_tx_encode #(.AW(AW), .STRAP(STRAP)) u_enc (
    .sel(enc_sel), .addr(addr_q), .wdata(wdata_q), .wire_byte(enc_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      slot    <= B_CW;
      step    <= 2'd0;
      bitn    <= 4'd0;
      sh      <= 8'hFF;
      rx      <= 8'h00;
      ack_bad <= 1'b0;
      nack_q  <= 1'b0;
      rw_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= 8'h00;
      busy    <= 1'b0;
      done    <= 1'b0;
      rdata   <= 8'h00;
      err     <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
          if (req) begin
            busy    <= 1'b1;
            err     <= 1'b0;
            nack_q  <= 1'b0;
            rw_q    <= rd_nwr;
            addr_q  <= addr;
            wdata_q <= wdata;
            slot    <= B_CW;
            step    <= 2'd0;
            state   <= ST_START;
          end
        end
        ST_START: if (tick) begin
          case (step)
            2'd0: begin scl_oe <= 1'b0; sda_oe <= 1'b0; step <= 2'd1; end
            2'd1: begin sda_oe <= 1'b1; step <= 2'd2; end
            default: begin
              scl_oe <= 1'b1;
              sh     <= enc_byte;
              bitn   <= 4'd0;
              step   <= 2'd0;
              state  <= ST_BIT;
            end
          endcase
        end
        ST_BIT: if (tick) begin
          case (step)
            2'd0: begin
              if (bitn != ACK_BIT && slot != B_RD) sda_oe <= ~sh[7];
              else                                 sda_oe <= 1'b0;
              step <= 2'd1;
            end
            2'd1: begin scl_oe <= 1'b0; step <= 2'd2; end
            2'd2: begin
              if (bitn == ACK_BIT) ack_bad <= sda_i;
              else begin
                rx <= {rx[6:0], sda_i};
                sh <= {sh[6:0], 1'b1};
              end
              step <= 2'd3;
            end
            default: begin
              scl_oe <= 1'b1;
              step   <= 2'd0;
              if (bitn != ACK_BIT) begin
                bitn <= bitn + 4'd1;
              end else begin
                bitn <= 4'd0;
                if (slot == B_RD) begin
                  rdata <= ~rx;
                  state <= ST_STOP;
                end else if (ack_bad) begin
                  nack_q <= 1'b1;
                  state  <= ST_STOP;
                end else if (slot == B_WD) begin
                  state <= ST_STOP;
                end else begin
                  slot <= slot_nx;
                  sh   <= enc_byte;
                  if (slot_nx == B_CR) state <= ST_RSTART;
                end
              end
            end
          endcase
        end
        ST_RSTART: if (tick) begin
          case (step)
            2'd0: begin sda_oe <= 1'b0; step <= 2'd1; end
            2'd1: begin scl_oe <= 1'b0; step <= 2'd2; end
            2'd2: begin sda_oe <= 1'b1; step <= 2'd3; end
            default: begin
              scl_oe <= 1'b1;
              sh     <= enc_byte;
              bitn   <= 4'd0;
              step   <= 2'd0;
              state  <= ST_BIT;
            end
          endcase
        end
        ST_STOP: if (tick) begin
          case (step)
            2'd0: begin sda_oe <= 1'b1; step <= 2'd1; end
            2'd1: begin scl_oe <= 1'b0; step <= 2'd2; end
            2'd2: begin sda_oe <= 1'b0; step <= 2'd3; end
            default: begin
              step  <= 2'd0;
              busy  <= 1'b0;
              done  <= 1'b1;
              err   <= nack_q;
              state <= ST_IDLE;
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lz_eeprom_chk.sv
module lz_eeprom_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic err,
  input logic scl_oe,
  input logic sda_oe,
  input logic in_bit
);
  // R10
  lines_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe));

  // R9
  done_once_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_free_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7
  sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_bit && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  // R8
  err_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);
endmodule

bind lz_eeprom_ctrl lz_eeprom_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .in_bit(bit_phase)
);

// File: tb/sim_lz_eeprom_ctrl.sv
`timescale 1ns/1ps
module sim_lz_eeprom_ctrl;
  logic clk = 1'b0, rst = 1'b1, req = 1'b0, rd_nwr = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic busy, done, err, scl_oe, sda_oe;
  logic [7:0] rdata;
  logic s_pull = 1'b0;
  logic sda_line, scl_line;

  assign sda_line = !(sda_oe || s_pull);
  assign scl_line = !scl_oe;

  always #2 clk = ~clk;

  lz_eeprom_ctrl u0 (
    .clk(clk), .rst(rst), .req(req), .rd_nwr(rd_nwr), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata), .err(err),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_line)
  );

  int checks = 0, fails = 0;
  bit finished = 0, armed = 0;
  logic [7:0] exp_q[$];

  int bitcnt = 0, byte_n = 0, nack_at = -1, starts = 0, stops = 0;
  int per_seen = 0, per_bad = 0;
  bit tx = 0, go_tx = 0, rise_ok = 0;
  logic [7:0] sh_in = '0, tx_byte = '0;
  logic m_ack = 1'b0;
  time last_rise = 0;
  logic got_err;
  logic [7:0] got_rd;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // scoreboard monitor: every byte the slave receives is compared in order
  task automatic log_byte(input logic [7:0] b);
    if (exp_q.size() == 0) chk("R5 unexpected byte on bus", {24'd0, b}, 32'hFFFF_FFFF);
    else chk($sformatf("R5 bus byte %0d", byte_n), {24'd0, b}, {24'd0, exp_q.pop_front()});
  endtask

  always @(posedge scl_line) if (armed) begin
    if (rise_ok) begin
      per_seen++;
      if ($time - last_rise != 64) per_bad++;
    end
    last_rise = $time;
    rise_ok = 1;
    if (bitcnt < 8) begin
      if (!tx) sh_in = {sh_in[6:0], sda_line};
      bitcnt++;
    end else begin
      if (tx) m_ack = sda_line;
      bitcnt = 9;
    end
  end

  always @(negedge scl_line) if (armed) begin
    if (bitcnt == 8) begin
      if (!tx) begin
        log_byte(sh_in);
        s_pull = (byte_n != nack_at);
        if (s_pull && sh_in == 8'hAF) go_tx = 1;
        byte_n++;
      end else s_pull = 1'b0;
    end else if (bitcnt == 9) begin
      bitcnt = 0;
      s_pull = 1'b0;
      if (tx) tx = 0;
      else if (go_tx) begin
        tx = 1; go_tx = 0;
        s_pull = !tx_byte[7];
      end
    end else if (tx) s_pull = !tx_byte[7-bitcnt];
  end

  always @(negedge sda_line) if (armed && scl_line) begin
    starts++; bitcnt = 0; tx = 0; go_tx = 0; s_pull = 1'b0; rise_ok = 0;
  end

  always @(posedge sda_line) if (armed && scl_line) begin
    stops++; bitcnt = 0; byte_n = 0; tx = 0; go_tx = 0;
  end

  // driver: issue one request and wait for its end
  task automatic run(input bit rd, input logic [12:0] a, input logic [7:0] d);
    int n;
    starts = 0; stops = 0;
    @(negedge clk);
    rd_nwr = rd; addr = a; wdata = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R9 busy after accept", {31'd0, busy}, 32'd1);
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk("R9 done reached", {31'd0, done}, 32'd1);
    chk("R9 busy low at done", {31'd0, busy}, 32'd0);
    chk("R10 lines released at done", {30'd0, scl_oe, sda_oe}, 32'd0);
    got_err = err;
    got_rd  = rdata;
    @(negedge clk);
    chk("R9 done single cycle", {31'd0, done}, 32'd0);
    chk("R5 scoreboard drained", exp_q.size(), 32'd0);
  endtask

  task automatic push_write(input logic [12:0] a, input logic [7:0] d);
    exp_q.push_back(8'hAE);                 // R2
    exp_q.push_back({3'b111, a[12:8]});     // R3
    exp_q.push_back(a[7:0]);                // R3
    exp_q.push_back(~d);                    // R4
  endtask

  task automatic push_read(input logic [12:0] a);
    exp_q.push_back(8'hAE);                 // R2
    exp_q.push_back({3'b111, a[12:8]});     // R3
    exp_q.push_back(a[7:0]);
    exp_q.push_back(8'hAF);                 // R6
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    armed = 1;
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
    chk("R1 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);

    // R3 R4 R5: 0x1BCC / 0x00 -> AE FB CC FF
    exp_q.push_back(8'hAE); exp_q.push_back(8'hFB);
    exp_q.push_back(8'hCC); exp_q.push_back(8'hFF);
    run(0, 13'h1BCC, 8'h00);
    chk("R8 err clear on good write", {31'd0, got_err}, 32'd0);
    chk("R5 single start on write", starts, 32'd1);
    chk("R8 stop on write", stops, 32'd1);

    // R3: 0x0000 / 0x00 -> AE E0 00 FF
    exp_q.push_back(8'hAE); exp_q.push_back(8'hE0);
    exp_q.push_back(8'h00); exp_q.push_back(8'hFF);
    run(0, 13'h0000, 8'h00);

    // R4 top of space, mixed data
    push_write(13'h1FFF, 8'hA5);
    run(0, 13'h1FFF, 8'hA5);

    // R6 read: wire byte 0x3C -> host sees 0xC3
    tx_byte = 8'h3C; m_ack = 1'b0;
    push_read(13'h0123);
    run(1, 13'h0123, 8'h00);
    chk("R6 read data inverted", {24'd0, got_rd}, 32'hC3);
    chk("R6 repeated start", starts, 32'd2);
    chk("R6 master NACK", {31'd0, m_ack}, 32'd1);
    chk("R6 no error", {31'd0, got_err}, 32'd0);

    // R6 read of all-ones wire byte
    tx_byte = 8'hFF; m_ack = 1'b0;
    push_read(13'h1ABC);
    run(1, 13'h1ABC, 8'h00);
    chk("R6 read data 00", {24'd0, got_rd}, 32'h00);
    chk("R6 master NACK second", {31'd0, m_ack}, 32'd1);

    // R8 slave refuses address-high byte of a write
    nack_at = 1;
    exp_q.push_back(8'hAE); exp_q.push_back(8'hE1);
    run(0, 13'h0123, 8'h77);
    chk("R8 err on refused address", {31'd0, got_err}, 32'd1);
    chk("R8 stop after refusal", stops, 32'd1);

    // R8 slave refuses control byte of a read
    nack_at = 0;
    exp_q.push_back(8'hAE);
    run(1, 13'h0456, 8'h00);
    chk("R8 err on refused control", {31'd0, got_err}, 32'd1);
    chk("R8 single start on refused read", starts, 32'd1);
    nack_at = -1;

    // R8 clean transfer clears err
    push_write(13'h0A0A, 8'h3C);
    run(0, 13'h0A0A, 8'h3C);
    chk("R8 err cleared", {31'd0, got_err}, 32'd0);

    // R11 SCL rising-edge spacing 16 clocks
    chk("R11 edges measured", {31'd0, per_seen > 0}, 32'd1);
    chk("R11 period mismatches", per_bad, 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #700000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R9 transfer never completed actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule